// File: doc/BRIEF.md
# Legacy Interrupt Virtual-Wire Messenger

This block sits on the endpoint side of a serial link. It turns a small set of level-sensitive legacy interrupt lines into posted in-band message headers. Each message takes the place of a physical pin. When a line becomes active, the block sends a message that marks that line asserted. When the line drops after service, it sends the matching message that marks it deasserted. The headers are four doublewords long and carry no payload. They go to a transmit arbiter over a valid/ready interface. The block never expects a completion for them.

For each line the block keeps the level that the far side has last been told about. A line has a pending message whenever its sampled, unmasked level differs from that recorded level. As a result, a pulse that comes and goes before its message is launched produces no traffic at all. Changes on one line also can never be reported out of order. The lowest-numbered line is served first. A global mask input works like a gate in front of every line: while it is set, no new assertion is sent, and every line that was reported asserted is reported deasserted.

Top module: `intx_vwire_msgr`

## Requirements
- R1: After reset, `msg_valid` is low and stays low until some unmasked line changes level.
- R2: When line i (bit i of `intx_lvl`, i = 0..3) rises, exactly one message goes out with message code 8'h20 + i.
- R3: When line i falls after its assertion was sent, exactly one message goes out with message code 8'h24 + i.
- R4: Header layout, with `msg_hdr[127:96]` as the first doubleword:
  - format `[127:125]` = 3'b001;
  - type `[124:120]` = 5'b10100, a message routed locally;
  - traffic class `[118:116]` = 0;
  - length `[105:96]` = 0, and all other bits of the first doubleword are zero.
  - In the second doubleword, `[95:80]` is the requester ID, `[79:72]` (tag) is zero and `[71:64]` is the message code.
  - `[63:0]` is zero.
- R5: When several lines need a message at the same time, the lowest-numbered line goes first.
- R6: If a line returns to the level last reported before its message is launched, no message is sent for it.
- R7: Messages for one line leave in the order of that line's level changes. A deassert never leaves before the assert it follows.
- R8: While `intx_mask` is high, no assert message is launched, and a deassert is sent for every line whose assert had been sent. When the mask is cleared, lines that are still high get assert messages.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and `msg_hdr` does not change.
- R10: The requester ID field carries the value of `requester_id` at the time the message is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_lvl | input | NUM_LINES | Level of each legacy interrupt line, bit 0 = first line |
| intx_mask | input | 1 | Global interrupt disable |
| requester_id | input | 16 | Identifier placed in every header |
| msg_valid | output | 1 | A header is offered |
| msg_ready | input | 1 | Arbiter takes the header this cycle |
| msg_hdr | output | 128 | Four-doubleword message header |

## Verification
The bench builds the block with its default of four lines and code base 8'h20. This puts every assert and deassert code within reach, as well as the full priority order from the first line to the last. By holding `msg_ready` low, the bench can keep a message in flight while other lines change level. That exposes three behaviours: collapsing of short pulses, per-line ordering of an assert followed by its deassert, and the hold-stable rule. Toggling the mask with lines already reported shows forced deasserts and re-asserts on unmask.

// File: rtl/intx_msg_pkg.sv
package intx_msg_pkg;

  localparam logic [2:0] FMT_4DW_NODATA = 3'b001;
  localparam logic [4:0] TYPE_MSG_LOCAL = 5'b10100;
  localparam int         HDR_W          = 128;
  localparam int         RID_W          = 16;

  typedef logic [HDR_W-1:0] hdr_t;

  function automatic hdr_t pack_hdr(input logic [RID_W-1:0] rid,
                                    input logic [7:0]       code);
    logic [31:0] dw0;
    logic [31:0] dw1;
    dw0 = {FMT_4DW_NODATA, TYPE_MSG_LOCAL, 24'h0};
    dw1 = {rid, 8'h00, code};
    return {dw0, dw1, 64'h0};
  endfunction

endpackage

// File: rtl/intx_line_track.sv
module intx_line_track #(
  parameter int NUM_LINES = 4,
  parameter int LW        = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lvl_in,
  input  logic                 mask_in,
  input  logic                 done,
  input  logic [LW-1:0]        done_line,
  input  logic                 done_asrt,
  output logic [NUM_LINES-1:0] pend_asrt,
  output logic [NUM_LINES-1:0] pend_deas
);

  logic [NUM_LINES-1:0] lvl_q;
  logic                 mask_q;
  logic [NUM_LINES-1:0] told_q;
  logic [NUM_LINES-1:0] told_nxt;
  logic [NUM_LINES-1:0] eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
    end else begin
      mask_q <= mask_in;
    end
  end

  always_comb begin
    told_nxt = told_q;
    if (done) begin
      told_nxt[done_line] = done_asrt;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_q[g]  <= 1'b0;
          told_q[g] <= 1'b0;
        end else begin
          lvl_q[g] <= lvl_in[g];
          if (done) begin
            told_q[g] <= told_nxt[g];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    eff       = lvl_q & ~{NUM_LINES{mask_q}};
    pend_asrt = eff & ~told_q;
    pend_deas = ~eff & told_q;
  end

  AST_NO_REDUNDANT_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (told_q[done_line] != done_asrt)) else $error("redundant message"); // R6

endmodule

// File: rtl/intx_prio_pick.sv
module intx_prio_pick #(
  parameter int NUM_LINES = 4,
  parameter int LW        = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req,
  output logic [NUM_LINES-1:0] grant,
  output logic [LW-1:0]        idx,
  output logic                 any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = LW'(i);
      end
    end
    any = |req;
  end

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (grant == (req & (~req + NUM_LINES'(1))))) else $error("priority"); // R5

endmodule

// File: rtl/intx_hdr_fmt.sv
module intx_hdr_fmt
  import intx_msg_pkg::*;
#(
  parameter int         NUM_LINES = 4,
  parameter int         LW        = 2,
  parameter logic [7:0] CODE_BASE = 8'h20
) (
  input  logic [LW-1:0]    line,
  input  logic             asrt,
  input  logic [RID_W-1:0] rid,
  output hdr_t             hdr
);

  localparam logic [7:0] DEAS_BASE = CODE_BASE + 8'(NUM_LINES);

  logic [7:0] code;

  always_comb begin
    code = (asrt ? CODE_BASE : DEAS_BASE) + 8'(line);
    hdr  = pack_hdr(rid, code);
  end

endmodule

// File: rtl/intx_vwire_msgr.sv
module intx_vwire_msgr
  import intx_msg_pkg::*;
#(
  parameter int         NUM_LINES = 4,
  parameter logic [7:0] CODE_BASE = 8'h20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] intx_lvl,
  input  logic                 intx_mask,
  input  logic [15:0]          requester_id,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [127:0]         msg_hdr
);

  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [1:0]           rst_sync;
  logic                 rst_i;
  logic [NUM_LINES-1:0] pend_asrt;
  logic [NUM_LINES-1:0] pend_deas;
  logic [NUM_LINES-1:0] grant;
  logic [LW-1:0]        pick_idx;
  logic                 pick_any;
  logic                 launch;
  logic                 accept;

  logic                 valid_q, valid_d;
  logic [LW-1:0]        line_q, line_d;
  logic                 asrt_q, asrt_d;
  logic [RID_W-1:0]     rid_q, rid_d;
  logic                 load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_i = rst_sync[1];

  intx_line_track #(.NUM_LINES(NUM_LINES), .LW(LW)) u_track (
    .clk       (clk),
    .rst_n     (rst_i),
    .lvl_in    (intx_lvl),
    .mask_in   (intx_mask),
    .done      (accept),
    .done_line (line_q),
    .done_asrt (asrt_q),
    .pend_asrt (pend_asrt),
    .pend_deas (pend_deas)
  );

  intx_prio_pick #(.NUM_LINES(NUM_LINES), .LW(LW)) u_pick (
    .clk   (clk),
    .rst_n (rst_i),
    .req   (pend_asrt | pend_deas),
    .grant (grant),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  always_comb begin
    accept  = valid_q & msg_ready;
    launch  = ~valid_q & pick_any;
    load_en = launch;
    valid_d = valid_q;
    line_d  = line_q;
    asrt_d  = asrt_q;
    rid_d   = rid_q;
    if (accept) begin
      valid_d = 1'b0;
    end
    if (launch) begin
      valid_d = 1'b1;
      line_d  = pick_idx;
      asrt_d  = |(grant & pend_asrt);
      rid_d   = requester_id;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      asrt_q  <= 1'b0;
      rid_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        line_q <= line_d;
        asrt_q <= asrt_d;
        rid_q  <= rid_d;
      end
    end
  end

  intx_hdr_fmt #(.NUM_LINES(NUM_LINES), .LW(LW), .CODE_BASE(CODE_BASE)) u_fmt (
    .line (line_q),
    .asrt (asrt_q),
    .rid  (rid_q),
    .hdr  (msg_hdr)
  );

  assign msg_valid = valid_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_i)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_hdr))) else $error("hold"); // R9

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_i)
    (msg_valid && msg_ready) |=> !msg_valid) else $error("in flight"); // R7

  AST_LAUNCH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(msg_valid) |-> $past(pick_any)) else $error("spurious launch"); // R1

endmodule

// File: tb/intx_vwire_msgr_tb.sv
module intx_vwire_msgr_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] intx_lvl;
  logic         intx_mask;
  logic [15:0]  requester_id;
  logic         msg_valid;
  logic         msg_ready;
  logic [127:0] msg_hdr;

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  intx_vwire_msgr u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .intx_lvl     (intx_lvl),
    .intx_mask    (intx_mask),
    .requester_id (requester_id),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_hdr      (msg_hdr)
  );

  function automatic logic [127:0] model_hdr(input int line, input bit asrt,
                                             input logic [15:0] rid);
    logic [7:0] code;
    code = (asrt ? 8'h20 : 8'h24) + 8'(line);
    return {3'b001, 5'b10100, 24'h0, rid, 8'h00, code, 64'h0};
  endfunction

  task automatic expect_msg(input int line, input bit asrt, input string req);
    exp_q.push_back(model_hdr(line, asrt, requester_id));
    tag_q.push_back(req);
  endtask

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #8;
    if (rst_n === 1'b1 && msg_valid === 1'b1 && msg_ready === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected message", msg_hdr, 128'h0);
      end else begin
        logic [127:0] e;
        string        t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(msg_hdr === e, t, msg_hdr, e);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain(input string req);
    cyc(30);
    #8;
    check(exp_q.size() == 0 && msg_valid == 1'b0, req,
          128'(exp_q.size()), 128'h0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", wd);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] snap;
    rst_n        = 1'b0;
    intx_lvl     = '0;
    intx_mask    = 1'b0;
    requester_id = 16'hABCD;
    msg_ready    = 1'b1;
    cyc(3);
    #8;
    check(msg_valid == 1'b0, "R1 valid in reset", 128'(msg_valid), 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(10);
    #8;
    check(msg_valid == 1'b0, "R1 idle after reset", 128'(msg_valid), 128'h0);

    // R2 R3 R4: single line A
    @(negedge clk);
    expect_msg(0, 1'b1, "R2 assert A");
    intx_lvl[0] = 1'b1;
    cyc(10);
    expect_msg(0, 1'b0, "R3 deassert A");
    intx_lvl[0] = 1'b0;
    drain("R4 line A pair");

    // R5 R9: priority with stalled arbiter
    @(negedge clk);
    msg_ready = 1'b0;
    intx_lvl  = 4'b1011;
    expect_msg(0, 1'b1, "R5 first A");
    expect_msg(1, 1'b1, "R5 then B");
    expect_msg(3, 1'b1, "R5 then D");
    cyc(5);
    #8;
    snap = msg_hdr;
    cyc(4);
    #8;
    check(msg_valid == 1'b1 && msg_hdr === snap, "R9 hold stable", msg_hdr, snap);
    @(negedge clk);
    msg_ready = 1'b1;
    cyc(12);
    expect_msg(0, 1'b0, "R3 deassert A");
    expect_msg(1, 1'b0, "R3 deassert B");
    expect_msg(3, 1'b0, "R3 deassert D");
    intx_lvl = 4'b0000;
    drain("R5 priority drain");

    // R6: pulse on C collapses while A is in flight
    @(negedge clk);
    msg_ready = 1'b0;
    expect_msg(0, 1'b1, "R6 assert A only");
    intx_lvl[0] = 1'b1;
    cyc(4);
    intx_lvl[2] = 1'b1;
    cyc(2);
    intx_lvl[2] = 1'b0;
    cyc(3);
    msg_ready = 1'b1;
    drain("R6 pulse collapsed");
    @(negedge clk);
    expect_msg(0, 1'b0, "R6 deassert A");
    intx_lvl[0] = 1'b0;
    drain("R6 drain");

    // R7: assert and deassert of B while stalled keep order
    @(negedge clk);
    msg_ready = 1'b0;
    expect_msg(1, 1'b1, "R7 assert B first");
    expect_msg(1, 1'b0, "R7 deassert B second");
    intx_lvl[1] = 1'b1;
    cyc(4);
    intx_lvl[1] = 1'b0;
    cyc(3);
    msg_ready = 1'b1;
    drain("R7 order");

    // R8: mask behaviour
    @(negedge clk);
    expect_msg(0, 1'b1, "R8 assert A before mask");
    intx_lvl[0] = 1'b1;
    cyc(10);
    expect_msg(0, 1'b0, "R8 forced deassert A");
    intx_mask = 1'b1;
    cyc(10);
    intx_lvl[2] = 1'b1;
    drain("R8 no assert while masked");
    @(negedge clk);
    expect_msg(0, 1'b1, "R8 reassert A on unmask");
    expect_msg(2, 1'b1, "R8 assert C on unmask");
    intx_mask = 1'b0;
    drain("R8 unmask drain");
    @(negedge clk);
    expect_msg(0, 1'b0, "R3 deassert A");
    expect_msg(2, 1'b0, "R3 deassert C");
    intx_lvl = '0;
    drain("R8 final drain");

    // R10: new requester id, line D
    @(negedge clk);
    requester_id = 16'h0102;
    expect_msg(3, 1'b1, "R10 id in assert D");
    intx_lvl[3] = 1'b1;
    cyc(10);
    expect_msg(3, 1'b0, "R10 id in deassert D");
    intx_lvl[3] = 1'b0;
    drain("R10 drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule